// File: doc/BRIEF.md
# Two-Subphase Address Parity Unit

This block produces and verifies the two address parity lines of a processor system bus whose address phase spans two consecutive subphases. All bus fields are active-low. A generator half forms both parity lines from the address field (bus bits 35 down to 3) and the 5-bit request field for whichever subphase the initiator has selected. The initiator drives these lines in the same cycle as the address strobe.

The receiver half starts work when it sees the address strobe. It waits until both strobe groups of the bus fields are reported captured, then compares the sampled parity lines against a recomputed value for subphase 1. In the next qualified clock it does the same for subphase 2. A registered error pulse is raised per parity line. Each parity line covers one slice in subphase 1 and the other slice in subphase 2, so the same data corruption shows up on a different line depending on the subphase.

Top module: `apar_unit`

## Requirements
- R1: A parity line is 1 when an even number of its covered active-low lines are 0, and 0 when that number is odd. When every covered line is 1, the parity line is 1.
- R2: When `tx_sub2`=0 (subphase 1), `tx_par_n[0]` covers the upper slice and `tx_par_n[1]` covers the lower slice plus all of `tx_req_n`. The generator output changes in the same cycle as its inputs. Port index k carries bus address bit k+3. The upper slice is index 32..21 (bus bits 35..24). The lower slice is index 20..0 (bus bits 23..3).
- R3: When `tx_sub2`=1 (subphase 2), the coverage swaps: `tx_par_n[1]` covers the upper slice and `tx_par_n[0]` covers the lower slice plus the request field.
- R4: A subphase-1 check is made in the clock where `rx_strobe`=1 and `rx_cap`=2'b11. Each `err_par` bit is 1 in the following cycle exactly when that received parity line disagrees with the R2 coverage, and `err_sub2` is 0 then.
- R5: The subphase-2 check uses the R3 coverage and is made in the next clock after the subphase-1 check in which `rx_cap`=2'b11. Its errors appear one cycle later, and `err_sub2`=1 whenever any `err_par` bit is set by it.
- R6: Without `rx_strobe`, no check is made: `err_par` stays 2'b00 whatever the data and parity inputs are.
- R7: A check consumes fields only when both capture flags are set (`rx_cap[0]` marks request bits and address bits 16..3; `rx_cap[1]` marks address bits 35..17). Until then the pending subphase waits and no error is reported.
- R8: `rx_strobe` is ignored while a transaction is pending. A strobe seen while waiting for the subphase-2 check does not restart subphase 1.
- R9: A synchronous active-high `rst` clears the pending subphase and drives `err_par` and `err_sub2` to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_addr_n | input | 33 | Initiator address field, active low, index k is bus bit k+3 |
| tx_req_n | input | 5 | Initiator request field, active low |
| tx_sub2 | input | 1 | Initiator subphase select: 0 first, 1 second |
| tx_par_n | output | 2 | Generated parity lines |
| rx_strobe | input | 1 | Address strobe observed (starts a transaction) |
| rx_cap | input | 2 | Strobe-group captured flags for the current subphase |
| rx_addr_n | input | 33 | Received address field, active low |
| rx_req_n | input | 5 | Received request field, active low |
| rx_par_n | input | 2 | Received parity lines |
| err_par | output | 2 | Per-line mismatch pulse, one cycle after the check |
| err_sub2 | output | 1 | Marks that the current error pulse is from subphase 2 |

## Verification
A receiver stuck in the wrong subphase state shows up at the ports in the cycle after the next qualified capture. A corruption in the upper slice then raises the wrong `err_par` bit, or raises `err_sub2` when it should not. A lost pending state shows up as a missing second-subphase check, seen one cycle after the capture. Generator coverage faults are visible combinationally on `tx_par_n`. They are exposed by flipping single lines in each slice under both subphase selects.

// File: rtl/apar_pkg.sv
package apar_pkg;

    localparam int unsigned GRP_N = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT1 = 2'd1,
        ST_WAIT2 = 2'd2
    } apar_st_e;

    typedef struct packed {
        apar_st_e   st;
        logic [1:0] err;
        logic       err_sub2;
    } apar_chk_regs_t;

endpackage

// File: rtl/apar_slice_par.sv
module apar_slice_par #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] lines_n,
    output logic         par_n
);
    logic odd_lows;

    always_comb begin
        odd_lows = ^(~lines_n);
        par_n    = ~odd_lows;
    end
endmodule

// File: rtl/apar_gen.sv
module apar_gen #(
    parameter int unsigned ADDR_W = 33,
    parameter int unsigned REQ_W  = 5,
    parameter int unsigned HI_W   = 12
) (
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic              sub2,
    output logic [1:0]        par_n
);
    localparam int unsigned LOA_W = ADDR_W - HI_W;
    localparam int unsigned LO_W  = LOA_W + REQ_W;

    logic [HI_W-1:0] hi_lines;
    logic [LO_W-1:0] lo_lines;
    logic [1:0]      slice_par;

    always_comb begin
        hi_lines = addr_n[ADDR_W-1:LOA_W];
        lo_lines = {req_n, addr_n[LOA_W-1:0]};
    end

    for (genvar g = 0; g < 2; g++) begin : g_slice
        if (g == 0) begin : g_hi
            apar_slice_par #(.W(HI_W)) u_par (.lines_n(hi_lines), .par_n(slice_par[g]));
        end else begin : g_lo
            apar_slice_par #(.W(LO_W)) u_par (.lines_n(lo_lines), .par_n(slice_par[g]));
        end
    end

    always_comb begin
        if (sub2) par_n = {slice_par[0], slice_par[1]};
        else      par_n = {slice_par[1], slice_par[0]};
    end
endmodule

// File: rtl/apar_chk.sv
module apar_chk
    import apar_pkg::*;
#(
    parameter int unsigned ADDR_W = 33,
    parameter int unsigned REQ_W  = 5,
    parameter int unsigned HI_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [GRP_N-1:0]  cap,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic [1:0]        par_n,
    output logic [1:0]        err,
    output logic              err_sub2
);
    apar_chk_regs_t r_q;
    apar_chk_regs_t r_d;
    logic [1:0]     exp_par_n;
    logic [1:0]     mism;
    logic           sub2_sel;
    logic           cap_ok;
    logic           chk_en;

    assign sub2_sel = (r_q.st == ST_WAIT2);
    assign cap_ok   = &cap;

    apar_gen #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_exp (
        .addr_n (addr_n),
        .req_n  (req_n),
        .sub2   (sub2_sel),
        .par_n  (exp_par_n)
    );

    assign mism = exp_par_n ^ par_n;

    always_comb begin
        r_d          = r_q;
        r_d.err      = '0;
        r_d.err_sub2 = 1'b0;
        chk_en       = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (strobe) begin
                    if (cap_ok) begin
                        chk_en = 1'b1;
                        r_d.st = ST_WAIT2;
                    end else begin
                        r_d.st = ST_WAIT1;
                    end
                end
            end
            ST_WAIT1: begin
                if (cap_ok) begin
                    chk_en = 1'b1;
                    r_d.st = ST_WAIT2;
                end
            end
            ST_WAIT2: begin
                if (cap_ok) begin
                    chk_en = 1'b1;
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (chk_en) begin
            r_d.err      = mism;
            r_d.err_sub2 = sub2_sel & (|mism);
        end
        if (rst) begin
            r_d.st       = ST_IDLE;
            r_d.err      = '0;
            r_d.err_sub2 = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign err      = r_q.err;
    assign err_sub2 = r_q.err_sub2;
endmodule

// File: rtl/apar_unit.sv
module apar_unit #(
    parameter int unsigned ADDR_W = 33,
    parameter int unsigned REQ_W  = 5,
    parameter int unsigned HI_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tx_addr_n,
    input  logic [REQ_W-1:0]  tx_req_n,
    input  logic              tx_sub2,
    output logic [1:0]        tx_par_n,
    input  logic              rx_strobe,
    input  logic [1:0]        rx_cap,
    input  logic [ADDR_W-1:0] rx_addr_n,
    input  logic [REQ_W-1:0]  rx_req_n,
    input  logic [1:0]        rx_par_n,
    output logic [1:0]        err_par,
    output logic              err_sub2
);
    apar_gen #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_gen (
        .addr_n (tx_addr_n),
        .req_n  (tx_req_n),
        .sub2   (tx_sub2),
        .par_n  (tx_par_n)
    );

    apar_chk #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .strobe   (rx_strobe),
        .cap      (rx_cap),
        .addr_n   (rx_addr_n),
        .req_n    (rx_req_n),
        .par_n    (rx_par_n),
        .err      (err_par),
        .err_sub2 (err_sub2)
    );
endmodule

// File: rtl/apar_unit_sva.sv
module apar_unit_sva #(
    parameter int unsigned ADDR_W = 33,
    parameter int unsigned REQ_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] tx_addr_n,
    input logic [REQ_W-1:0]  tx_req_n,
    input logic              tx_sub2,
    input logic [1:0]        tx_par_n,
    input logic [1:0]        rx_cap,
    input logic [1:0]        err_par,
    input logic              err_sub2
);
    AST_ALL_HIGH_PAR: assert property (@(posedge clk) disable iff (rst)
        ((&tx_addr_n) && (&tx_req_n)) |-> (tx_par_n == 2'b11)); // R1

    AST_SUBPHASE_SWAP: assert property (@(posedge clk) disable iff (rst)
        ($stable(tx_addr_n) && $stable(tx_req_n) && (tx_sub2 != $past(tx_sub2)))
        |-> (tx_par_n == {$past(tx_par_n[0]), $past(tx_par_n[1])})); // R3

    AST_ERR_NEEDS_CAP: assert property (@(posedge clk) disable iff (rst)
        (|err_par) |-> ($past(rx_cap) == 2'b11)); // R7

    AST_SUB2_FLAG_QUAL: assert property (@(posedge clk) disable iff (rst)
        err_sub2 |-> (|err_par)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ((err_par == 2'b00) && !err_sub2)); // R9
endmodule

bind apar_unit apar_unit_sva #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .tx_addr_n (tx_addr_n),
    .tx_req_n  (tx_req_n),
    .tx_sub2   (tx_sub2),
    .tx_par_n  (tx_par_n),
    .rx_cap    (rx_cap),
    .err_par   (err_par),
    .err_sub2  (err_sub2)
);

// File: tb/apar_unit_bench.sv
module apar_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [32:0] tx_addr_n = '1;
    logic [4:0]  tx_req_n = '1;
    logic        tx_sub2 = 1'b0;
    logic [1:0]  tx_par_n;
    logic        rx_strobe = 1'b0;
    logic [1:0]  rx_cap = 2'b00;
    logic [32:0] rx_addr_n = '1;
    logic [4:0]  rx_req_n = '1;
    logic [1:0]  rx_par_n = 2'b11;
    logic [1:0]  err_par;
    logic        err_sub2;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    apar_unit u_apar_unit (
        .clk(clk), .rst(rst),
        .tx_addr_n(tx_addr_n), .tx_req_n(tx_req_n), .tx_sub2(tx_sub2), .tx_par_n(tx_par_n),
        .rx_strobe(rx_strobe), .rx_cap(rx_cap), .rx_addr_n(rx_addr_n), .rx_req_n(rx_req_n),
        .rx_par_n(rx_par_n), .err_par(err_par), .err_sub2(err_sub2)
    );

    // stimulus and expected subphase-1 parity {line1, line0}; subphase 2 is the swap
    localparam logic [32:0] VA [7] = '{33'h1_FFFF_FFFF, 33'h0_0000_0000, 33'h1_FFFF_FFFF,
                                       33'h1_FFFF_FFFE, 33'h0_FFFF_FFFF, 33'h1_FFCF_FFFF,
                                       33'h0_0000_0000};
    localparam logic [4:0]  VR [7] = '{5'h1F, 5'h00, 5'h00, 5'h1F, 5'h1F, 5'h1F, 5'h1F};
    localparam logic [1:0]  VP [7] = '{2'b11, 2'b11, 2'b01, 2'b01, 2'b10, 2'b00, 2'b01};

    function automatic logic [1:0] ref_par(logic [32:0] a, logic [4:0] r, bit s2);
        int hi_lows = 0;
        int lo_lows = 0;
        logic ph;
        logic pl;
        for (int i = 21; i < 33; i++) if (!a[i]) hi_lows++;
        for (int i = 0; i < 21; i++) if (!a[i]) lo_lows++;
        for (int i = 0; i < 5; i++) if (!r[i]) lo_lows++;
        ph = (hi_lows % 2 == 0);
        pl = (lo_lows % 2 == 0);
        return s2 ? {ph, pl} : {pl, ph};
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_rx();
        rx_strobe = 1'b0;
        rx_cap    = 2'b00;
    endtask

    // full transaction: parity from clean data, data driven with flip masks
    task automatic txn(input string tag,
                       input logic [32:0] a1, input logic [4:0] r1,
                       input logic [32:0] fa1, input logic [4:0] fr1,
                       input logic [32:0] a2, input logic [4:0] r2,
                       input logic [32:0] fa2, input logic [4:0] fr2);
        logic [1:0] e1;
        logic [1:0] e2;
        e1 = ref_par(a1, r1, 1'b0) ^ ref_par(a1 ^ fa1, r1 ^ fr1, 1'b0);
        e2 = ref_par(a2, r2, 1'b1) ^ ref_par(a2 ^ fa2, r2 ^ fr2, 1'b1);
        @(negedge clk);
        rx_strobe = 1'b1; rx_cap = 2'b11;
        rx_addr_n = a1 ^ fa1; rx_req_n = r1 ^ fr1; rx_par_n = ref_par(a1, r1, 1'b0);
        @(negedge clk);
        check({tag, " R4 sub1 err"}, {1'b0, err_sub2, err_par}, {1'b0, 1'b0, e1});
        rx_strobe = 1'b0;
        rx_addr_n = a2 ^ fa2; rx_req_n = r2 ^ fr2; rx_par_n = ref_par(a2, r2, 1'b1);
        @(negedge clk);
        check({tag, " R5 sub2 err"}, {1'b0, err_sub2, err_par}, {1'b0, |e2, e2});
        idle_rx();
        @(negedge clk);
        check({tag, " R5 pulse ends"}, {2'b00, err_par}, 4'h0);
    endtask

    localparam logic [32:0] HI_BIT = 33'h1_0000_0000;
    localparam logic [32:0] LO_BIT = 33'h0_0000_0001;
    localparam logic [32:0] A_X    = 33'h1_2345_6789;

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset state", {1'b0, err_sub2, err_par}, 4'h0);
        rst = 1'b0;

        // generator table walk (R1, R2, R3)
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            tx_addr_n = VA[i]; tx_req_n = VR[i]; tx_sub2 = 1'b0;
            #1;
            check($sformatf("R1 R2 gen sub1 vec%0d", i), {2'b00, tx_par_n}, {2'b00, VP[i]});
            check($sformatf("R2 ref sub1 vec%0d", i), {2'b00, tx_par_n}, {2'b00, ref_par(VA[i], VR[i], 1'b0)});
            @(negedge clk);
            tx_sub2 = 1'b1;
            #1;
            check($sformatf("R3 gen sub2 vec%0d", i), {2'b00, tx_par_n}, {2'b00, VP[i][0], VP[i][1]});
        end
        // generator single flips per slice and subphase
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            tx_sub2 = s[0];
            tx_addr_n = A_X ^ HI_BIT; tx_req_n = 5'h15;
            #1;
            check($sformatf("R2 R3 gen hi flip s%0d", s), {2'b00, tx_par_n}, {2'b00, ref_par(A_X ^ HI_BIT, 5'h15, s[0])});
            tx_addr_n = A_X; tx_req_n = 5'h14;
            #1;
            check($sformatf("R2 R3 gen req flip s%0d", s), {2'b00, tx_par_n}, {2'b00, ref_par(A_X, 5'h14, s[0])});
        end

        // checker: clean, then single flips in each slice per subphase
        txn("clean", A_X, 5'h0A, '0, '0, 33'h0_FEDC_BA98, 5'h13, '0, '0);
        txn("sub1 hi flip", A_X, 5'h0A, HI_BIT, '0, A_X, 5'h0A, '0, '0);
        txn("sub1 lo flip", A_X, 5'h0A, LO_BIT, '0, A_X, 5'h0A, '0, '0);
        txn("sub1 req flip", A_X, 5'h0A, '0, 5'h01, A_X, 5'h0A, '0, '0);
        txn("sub2 hi flip", A_X, 5'h0A, '0, '0, A_X, 5'h0A, 33'h0_0020_0000, '0);
        txn("sub2 lo flip", A_X, 5'h0A, '0, '0, A_X, 5'h0A, 33'h0_0010_0000, '0);
        txn("both slices", '1, 5'h1F, HI_BIT | LO_BIT, '0, '0, '0, HI_BIT, 5'h10);

        // R6: no strobe, corrupted data with capture flags set
        @(negedge clk);
        rx_cap = 2'b11; rx_addr_n = A_X ^ HI_BIT; rx_req_n = 5'h0A; rx_par_n = ref_par(A_X, 5'h0A, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6 no strobe no check", {2'b00, err_par}, 4'h0);
        end
        idle_rx();

        // R7: strobe without full capture defers the subphase-1 check
        @(negedge clk);
        rx_strobe = 1'b1; rx_cap = 2'b01; rx_addr_n = A_X ^ LO_BIT; rx_req_n = 5'h0A;
        rx_par_n = ref_par(A_X, 5'h0A, 1'b0);
        @(negedge clk);
        check("R7 partial capture no err", {2'b00, err_par}, 4'h0);
        rx_strobe = 1'b0; rx_cap = 2'b10;
        @(negedge clk);
        check("R7 still waiting", {2'b00, err_par}, 4'h0);
        rx_cap = 2'b11; rx_addr_n = A_X ^ HI_BIT;
        @(negedge clk);
        check("R7 deferred sub1 check", {1'b0, err_sub2, err_par}, 4'h1);
        rx_addr_n = A_X; rx_par_n = ref_par(A_X, 5'h0A, 1'b1);
        @(negedge clk);
        check("R7 sub2 after deferral", {1'b0, err_sub2, err_par}, 4'h0);
        idle_rx();

        // R8: strobe during pending subphase 2 is ignored
        @(negedge clk);
        rx_strobe = 1'b1; rx_cap = 2'b11; rx_addr_n = A_X; rx_req_n = 5'h0A;
        rx_par_n = ref_par(A_X, 5'h0A, 1'b0);
        @(negedge clk);
        check("R8 first sub1 clean", {2'b00, err_par}, 4'h0);
        rx_strobe = 1'b1; rx_cap = 2'b00;
        @(negedge clk);
        check("R8 waiting no err", {2'b00, err_par}, 4'h0);
        rx_strobe = 1'b0; rx_cap = 2'b11; rx_addr_n = A_X ^ HI_BIT;
        rx_par_n = ref_par(A_X, 5'h0A, 1'b1);
        @(negedge clk);
        check("R8 checked as sub2", {1'b0, err_sub2, err_par}, 4'h6);
        idle_rx();
        @(negedge clk);
        check("R8 back to idle", {2'b00, err_par}, 4'h0);

        // R9: reset drops a pending transaction
        rx_strobe = 1'b1; rx_cap = 2'b11; rx_addr_n = A_X; rx_par_n = ref_par(A_X, 5'h0A, 1'b0);
        @(negedge clk);
        idle_rx();
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset clears err", {1'b0, err_sub2, err_par}, 4'h0);
        rst = 1'b0; rx_cap = 2'b11; rx_addr_n = A_X ^ HI_BIT;
        @(negedge clk);
        check("R9 pending dropped", {1'b0, err_sub2, err_par}, 4'h0);
        idle_rx();
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule